// File: doc/BRIEF.md
# 3D Mesh Route Computation Unit

This block works out where one input port of a 3D mesh router should send a packet. The mesh may have only some vertical links. A packet header gives the destination column, row and layer. The block compares these with the router's own coordinates and produces a set of candidate directions. It then trims that set for each of two virtual networks using a negative-first turn rule. Finally it picks the least congested legal port that is actually connected. The chosen output port is given as a one-hot vector, together with a one-bit virtual network index.

The route is worked out in a single pass of logic and registered once. It appears one clock cycle after the header is presented, and it carries a valid flag that follows the header-valid input. Routers with 5, 6 or 7 ports are built through two parameters that remove the Up or Down port. A per-port link mask also lets the surrounding logic exclude ports that are unconnected at run time, such as mesh edges or a layer with no vertical pillar.

Top module: `rcu3d_route`

## Requirements
- R1: Direction encoding. East means the destination column is greater than the current column and West means it is smaller. North means the destination row is greater and South means it is smaller. Up means the destination layer is greater and Down means it is smaller. Several directions may be required at once.
- R2: The port vector bit positions are fixed: bit 0 Local, bit 1 West, bit 2 South, bit 3 Down, bit 4 East, bit 5 North, bit 6 Up.
- R3: Virtual network 0 follows strict negative-first. While any of West, South or Down is required, only the required ones among those three are legal. Otherwise only the required ones among East, North and Up are legal.
- R4: Virtual network 1 applies negative-first to the plane only. It allows the required West or South moves, or, when neither is required, the required East or North moves. A required Up or Down move is legal on virtual network 1 at any time.
- R5: When all three coordinates match, only Local is legal on both networks. Local is selected with virtual network 0.
- R6: The port is chosen from the union of both networks' legal sets, restricted to ports that are connected and present. The chosen port is the one with the smallest congestion value.
- R7: Congestion ties go to the lowest bit position in the R2 order.
- R8: The reported virtual network is 0 when the chosen port is legal on network 0, and 1 otherwise.
- R9: A port whose mask bit is clear, or that is removed by a parameter, is never chosen. If no eligible port remains, the port vector is all zeros and the network index is 0.
- R10: Results appear one cycle after the header-valid input. The valid flag equals the header-valid input of the previous cycle. While the flag is low, the port vector and the network index are zero.
- R11: Synchronous reset clears the valid flag, the port vector and the network index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| hdr_valid_i | input | 1 | a header is present this cycle |
| dst_x_i | input | COORD_W | destination column |
| dst_y_i | input | COORD_W | destination row |
| dst_z_i | input | COORD_W | destination layer |
| cur_x_i | input | COORD_W | this router's column |
| cur_y_i | input | COORD_W | this router's row |
| cur_z_i | input | COORD_W | this router's layer |
| link_up_i | input | 7 | per-port connected mask, R2 order |
| cong_i | input | 7*CONG_W | per-port congestion, port p at bits p*CONG_W upward |
| route_valid_o | output | 1 | result valid |
| port_o | output | 7 | one-hot chosen port, R2 order |
| vn_o | output | 1 | chosen virtual network |

## Verification
The bench targets these corner cases:
- **A destination needing both East and Down.** A design that mixes up the two networks would send the packet East on network 0 and break the turn rule. It would also fail to fall back to East on network 1 when Down is congested or unlinked.
- **A congestion tie between East and North.** This exposes a reversed priority.
- **A destination reachable only through a missing Down link.** This must give an all-zero vector, never a stray port.
- **A northwest destination where West is congested.** This catches a selector that ignores legality.
- **Idle cycles between headers.** These catch stale outputs.

Randomised headers, masks and congestion levels are then checked against an independent model of the rules.

// File: rtl/rcu3d_pkg.sv
package rcu3d_pkg;
  localparam int NPORT = 7;
  localparam int NVN   = 2;
  localparam int P_L = 0;
  localparam int P_W = 1;
  localparam int P_S = 2;
  localparam int P_D = 3;
  localparam int P_E = 4;
  localparam int P_N = 5;
  localparam int P_U = 6;

  typedef logic [NPORT-1:0] portvec_t;

  localparam portvec_t NEG_ALL = portvec_t'((1 << P_W) | (1 << P_S) | (1 << P_D));
  localparam portvec_t POS_ALL = portvec_t'((1 << P_E) | (1 << P_N) | (1 << P_U));
  localparam portvec_t NEG_PLN = portvec_t'((1 << P_W) | (1 << P_S));
  localparam portvec_t POS_PLN = portvec_t'((1 << P_E) | (1 << P_N));
  localparam portvec_t VERT    = portvec_t'((1 << P_U) | (1 << P_D));
  localparam portvec_t LOC     = portvec_t'(1 << P_L);
endpackage

// File: rtl/rcu3d_dir.sv
module rcu3d_dir
  import rcu3d_pkg::*;
#(
  parameter int COORD_W = 3
) (
  input  logic [COORD_W-1:0] dx,
  input  logic [COORD_W-1:0] dy,
  input  logic [COORD_W-1:0] dz,
  input  logic [COORD_W-1:0] cx,
  input  logic [COORD_W-1:0] cy,
  input  logic [COORD_W-1:0] cz,
  output portvec_t           need_o
);
  always_comb begin
    need_o      = '0;
    need_o[P_W] = dx < cx;
    need_o[P_E] = dx > cx;
    need_o[P_S] = dy < cy;
    need_o[P_N] = dy > cy;
    need_o[P_D] = dz < cz;
    need_o[P_U] = dz > cz;
    need_o[P_L] = (dx == cx) && (dy == cy) && (dz == cz);
  end
endmodule

// File: rtl/rcu3d_turn.sv
module rcu3d_turn
  import rcu3d_pkg::*;
(
  input  portvec_t                    need_i,
  output logic [NVN-1:0][NPORT-1:0]   legal_o
);
  for (genvar v = 0; v < NVN; v++) begin : g_vn
    if (v == 0) begin : g_strict
      always_comb begin
        if (need_i[P_L])               legal_o[v] = LOC;
        else if ((need_i & NEG_ALL) != '0) legal_o[v] = need_i & NEG_ALL;
        else                           legal_o[v] = need_i & POS_ALL;
      end
    end else begin : g_planar
      always_comb begin
        if (need_i[P_L])                   legal_o[v] = LOC;
        else if ((need_i & NEG_PLN) != '0) legal_o[v] = (need_i & NEG_PLN) | (need_i & VERT);
        else                               legal_o[v] = (need_i & POS_PLN) | (need_i & VERT);
      end
    end
  end
endmodule

// File: rtl/rcu3d_sel.sv
module rcu3d_sel
  import rcu3d_pkg::*;
#(
  parameter int CONG_W = 4
) (
  input  portvec_t                  elig_i,
  input  logic [NPORT*CONG_W-1:0]   cong_i,
  output portvec_t                  sel_o
);
  logic [CONG_W-1:0] best;
  logic              found;

  always_comb begin
    sel_o = '0;
    best  = '0;
    found = 1'b0;
    for (int p = 0; p < NPORT; p++) begin
      if (elig_i[p] && (!found || cong_i[p*CONG_W +: CONG_W] < best)) begin
        sel_o    = '0;
        sel_o[p] = 1'b1;
        best     = cong_i[p*CONG_W +: CONG_W];
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rcu3d_route.sv
module rcu3d_route
  import rcu3d_pkg::*;
#(
  parameter int COORD_W  = 3,
  parameter int CONG_W   = 4,
  parameter bit HAS_UP   = 1'b1,
  parameter bit HAS_DOWN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hdr_valid_i,
  input  logic [COORD_W-1:0]      dst_x_i,
  input  logic [COORD_W-1:0]      dst_y_i,
  input  logic [COORD_W-1:0]      dst_z_i,
  input  logic [COORD_W-1:0]      cur_x_i,
  input  logic [COORD_W-1:0]      cur_y_i,
  input  logic [COORD_W-1:0]      cur_z_i,
  input  logic [NPORT-1:0]        link_up_i,
  input  logic [NPORT*CONG_W-1:0] cong_i,
  output logic                    route_valid_o,
  output logic [NPORT-1:0]        port_o,
  output logic                    vn_o
);
  localparam portvec_t PRESENT = ~portvec_t'((HAS_UP ? 0 : (1 << P_U)) |
                                             (HAS_DOWN ? 0 : (1 << P_D)));

  portvec_t                  need, elig, sel;
  logic [NVN-1:0][NPORT-1:0] legal;
  logic                      vn_next;

  rcu3d_dir #(.COORD_W(COORD_W)) u_dir (
    .dx(dst_x_i), .dy(dst_y_i), .dz(dst_z_i),
    .cx(cur_x_i), .cy(cur_y_i), .cz(cur_z_i),
    .need_o(need)
  );

  rcu3d_turn u_turn (.need_i(need), .legal_o(legal));

  assign elig = (legal[0] | legal[1]) & link_up_i & PRESENT;

  rcu3d_sel #(.CONG_W(CONG_W)) u_sel (.elig_i(elig), .cong_i(cong_i), .sel_o(sel));

  assign vn_next = (sel != '0) && ((sel & legal[0]) == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      route_valid_o <= 1'b0;
      port_o        <= '0;
      vn_o          <= 1'b0;
    end else begin
      route_valid_o <= hdr_valid_i;
      port_o        <= hdr_valid_i ? sel : '0;
      vn_o          <= hdr_valid_i ? vn_next : 1'b0;
    end
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_valid_i |=> route_valid_o);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !hdr_valid_i |=> (port_o == '0 && !vn_o));

  // R9
  masked_port_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_valid_i |=> (port_o & ~($past(link_up_i) & PRESENT)) == '0);

  // R6
  single_port_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(port_o));

  // R5
  local_only_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_valid_i && dst_x_i == cur_x_i && dst_y_i == cur_y_i && dst_z_i == cur_z_i
      && link_up_i[P_L] |=> (port_o[P_L] && !vn_o));
endmodule

// File: tb/rcu3d_route_tb.sv
module rcu3d_route_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 3;
  localparam int GW = 4;

  logic clk = 1'b0;
  logic rst;
  logic hv;
  logic [CW-1:0] dx, dy, dz, cx, cy, cz;
  logic [6:0] mask;
  logic [7*GW-1:0] cong;
  logic rv;
  logic [6:0] port;
  logic vn;

  int checks = 0;
  int fails = 0;
  logic [7:0] expq[$];
  string tagq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rcu3d_route #(.COORD_W(CW), .CONG_W(GW)) dut_i (
    .clk(clk), .rst(rst), .hdr_valid_i(hv),
    .dst_x_i(dx), .dst_y_i(dy), .dst_z_i(dz),
    .cur_x_i(cx), .cur_y_i(cy), .cur_z_i(cz),
    .link_up_i(mask), .cong_i(cong),
    .route_valid_o(rv), .port_o(port), .vn_o(vn)
  );

  // Bit order (R2): L0 W1 S2 D3 E4 N5 U6
  function automatic logic [7:0] model(input logic [CW-1:0] ax, ay, az, bx, by, bz,
                                       input logic [6:0] m, input logic [7*GW-1:0] c);
    logic w, s, d, e, n, u;
    logic [6:0] s0, s1, el, pick;
    logic [GW-1:0] lo;
    logic got;
    w = ax < bx; e = ax > bx; s = ay < by; n = ay > by; d = az < bz; u = az > bz;
    if (!(w | s | d | e | n | u)) begin
      s0 = 7'b0000001; s1 = 7'b0000001;
    end else begin
      if (w | s | d) s0 = {1'b0, 1'b0, 1'b0, d, s, w, 1'b0};
      else           s0 = {u, n, e, 1'b0, 1'b0, 1'b0, 1'b0};
      if (w | s) s1 = {u, 1'b0, 1'b0, d, s, w, 1'b0};
      else       s1 = {u, n, e, d, 1'b0, 1'b0, 1'b0};
    end
    el = (s0 | s1) & m;
    pick = '0; lo = '0; got = 1'b0;
    for (int p = 0; p < 7; p++)
      if (el[p] && (!got || c[p*GW +: GW] < lo)) begin
        pick = 7'(1 << p); lo = c[p*GW +: GW]; got = 1'b1;
      end
    return {(pick != 0) && ((pick & s0) == 0), pick};
  endfunction

  function automatic logic [7*GW-1:0] cg(input int l, w, s, d, e, n, u);
    return {GW'(u), GW'(n), GW'(e), GW'(d), GW'(s), GW'(w), GW'(l)};
  endfunction

  task automatic send(input string tag, input int ax, ay, az, bx, by, bz,
                      input logic [6:0] m, input logic [7*GW-1:0] c);
    @(negedge clk);
    hv = 1'b1;
    dx = CW'(ax); dy = CW'(ay); dz = CW'(az);
    cx = CW'(bx); cy = CW'(by); cz = CW'(bz);
    mask = m; cong = c;
    expq.push_back(model(dx, dy, dz, cx, cy, cz, mask, cong));
    tagq.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    hv = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && rv) begin
      logic [7:0] ex;
      string t;
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected result port=%b vn=%0d expected none", port, vn);
      end else begin
        ex = expq.pop_front();
        t = tagq.pop_front();
        if ({vn, port} !== ex) begin
          fails++;
          $display("FAIL %s port=%b vn=%0d expected port=%b vn=%0d", t, port, vn, ex[6:0], ex[7]);
        end
      end
    end
  end

  task automatic check_idle(input string tag);
    @(negedge clk);
    checks++;
    if (rv !== 1'b0 || port !== 7'b0 || vn !== 1'b0) begin
      fails++;
      $display("FAIL %s rv=%b port=%b vn=%b expected 0 0 0", tag, rv, port, vn);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; hv = 1'b0;
    dx = '0; dy = '0; dz = '0; cx = '0; cy = '0; cz = '0;
    mask = 7'h7f; cong = '0;
    repeat (3) @(posedge clk);
    check_idle("R11 reset");
    rst = 1'b0;
    // R5 local
    send("R5 local", 2, 3, 1, 2, 3, 1, 7'h7f, cg(9, 0, 0, 0, 0, 0, 0));
    // R3 northwest: W only even when congested
    send("R3 northwest", 1, 5, 2, 3, 2, 2, 7'h7f, cg(0, 15, 0, 0, 0, 0, 0));
    // R6 northeast, N less congested
    send("R6 northeast", 5, 5, 2, 3, 2, 2, 7'h7f, cg(0, 0, 0, 0, 5, 2, 0));
    // R7 tie E vs N -> E
    send("R7 tie", 5, 5, 2, 3, 2, 2, 7'h7f, cg(0, 0, 0, 0, 3, 3, 0));
    // R3/R8 east+down, D cheaper -> D vn0
    send("R8 east-down vn0", 5, 2, 0, 3, 2, 2, 7'h7f, cg(0, 0, 0, 1, 9, 0, 0));
    // R4/R8 east+down, E cheaper -> E vn1
    send("R4 east-down vn1", 5, 2, 0, 3, 2, 2, 7'h7f, cg(0, 0, 0, 9, 1, 0, 0));
    // R9 down unlinked -> E vn1
    send("R9 down unlinked", 5, 2, 0, 3, 2, 2, 7'h77, cg(0, 0, 0, 0, 9, 0, 0));
    idle();
    check_idle("R10 idle gap");
    // R9 only down needed, no link -> none
    send("R9 no route", 3, 2, 0, 3, 2, 2, 7'h77, cg(0, 0, 0, 0, 0, 0, 0));
    // R4 south+up, U cheaper -> U vn1
    send("R4 south-up", 3, 0, 4, 3, 2, 2, 7'h7f, cg(0, 0, 7, 0, 0, 0, 2));
    // R1 pure up
    send("R1 up", 3, 2, 6, 3, 2, 2, 7'h7f, cg(0, 0, 0, 0, 0, 0, 0));
    // R1 pure south
    send("R1 south", 3, 0, 2, 3, 2, 2, 7'h7f, cg(0, 0, 0, 0, 0, 0, 0));
    for (int i = 0; i < 300; i++) begin
      send("R6 random", $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
           $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
           7'($urandom) | 7'h01, (7*GW)'({$urandom, $urandom}));
      if ((i % 7) == 0) idle();
    end
    idle();
    check_idle("R10 final idle");
    repeat (2) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL R10 results missing=%0d expected 0", expq.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule